// File: doc/BRIEF.md
# Bidirectional Pin Bank with Peripheral Takeover

This block is an eight-pin general-purpose I/O bank. Software sees three register views through a small read/write bus. The first holds the per-pin direction bits. The second holds the output latch. The third returns the sampled pin levels. Each pin drives the pad through separate data-out, output-enable and data-in signals. A direction bit of 1 leaves the pin as a high-impedance input, and a direction bit of 0 drives the latch value onto it.

On-chip peripherals can take over any pin. While a pin's peripheral select is high, the peripheral's data replaces the latch value, and the peripheral's own output enable replaces the direction bit. The stored direction bits never change when this happens. A read-modify-write of the direction register therefore keeps the software's intent. The synchronized pin levels are also returned to the peripherals.

Top module: `pinbank_ovr`

## Requirements
- R1: After reset every direction bit reads 1, the latch reads 0 and every pad output enable is 0.
- R2: A write with `bus_addr` = 0 stores `bus_wdata` into the direction register at the next clock edge, and reading address 0 returns it.
- R3: A write with `bus_addr` = 1 or `bus_addr` = 2 stores `bus_wdata` into the output latch at the next clock edge. Reading address 1 returns the latch contents and never the pin level.
- R4: Reading address 2 returns the pin levels through a two-flop synchronizer. A change on `pad_in` before clock edge k becomes visible after edge k+1. `per_din` carries the same synchronized value.
- R5: For a pin whose select bit is 0, `pad_out` equals its latch bit and `pad_oe` equals the inverse of its direction bit.
- R6: For a pin whose select bit is 1, `pad_out` equals `per_dout` and `pad_oe` equals `per_oe` for that pin.
- R7: `per_oe` and `per_dout` have no effect on a pin whose select bit is 0.
- R8: Peripheral takeover never alters the direction register. Reading address 0 returns the last value software wrote, whatever the select bits are.
- R9: Address 3 reads as 0, and a write to it changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pins, 3 unused |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| per_sel | input | 8 | Per-pin peripheral takeover select |
| per_oe | input | 8 | Per-pin peripheral output enable |
| per_dout | input | 8 | Per-pin peripheral output data |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Data driven toward each pad |
| pad_oe | output | 8 | Pad driver enable, 1 = drive |
| per_din | output | 8 | Synchronized pin levels for peripherals |

## Verification
The clocked checks assume that `bus_addr`, `bus_we` and the peripheral inputs change at most once per clock period, away from the sampling edge. They also assume that read data is judged only against the address present at that edge. The bench changes every input on the falling edge and holds it across the next rising edge. It compares outputs a little after that edge, once the combinational read and pad paths have settled. `pad_in` is held steady through the vector table, and it moves only in the synchronizer test, so that latency can be counted edge by edge.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
    localparam int PB_AW = 2;

    typedef enum logic [PB_AW-1:0] {
        PB_DIR  = 2'd0,
        PB_LAT  = 2'd1,
        PB_PIN  = 2'd2,
        PB_NONE = 2'd3
    } pb_addr_e;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int NST = (STAGES < 2) ? 2 : STAGES;

    logic [W-1:0] chain_d [NST];
    logic [W-1:0] chain_q [NST];

    for (genvar g = 0; g < NST; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb chain_d[g] = async_i;
        end else begin : g_rest
            always_comb chain_d[g] = chain_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign sync_o = chain_q[NST-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PB_AW-1:0] addr,
    input  logic             we,
    input  logic [W-1:0]     wdata,
    input  logic [W-1:0]     pin_sync,
    output logic [W-1:0]     rdata,
    output logic [W-1:0]     dir_o,
    output logic [W-1:0]     lat_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
    } regs_t;

    regs_t    st_d, st_q;
    pb_addr_e sel_a;

    assign sel_a = pb_addr_e'(addr);

    always_comb begin
        st_d = st_q;
        if (we) begin
            case (sel_a)
                PB_DIR:         st_d.dir = wdata;
                PB_LAT, PB_PIN: st_d.lat = wdata;
                default:        ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir <= '1;
            st_q.lat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (sel_a)
            PB_DIR:  rdata = st_q.dir;
            PB_LAT:  rdata = st_q.lat;
            PB_PIN:  rdata = pin_sync;
            default: rdata = '0;
        endcase
    end

    assign dir_o = st_q.dir;
    assign lat_o = st_q.lat;

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == PB_DIR) |=> $stable(st_q.dir));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == PB_DIR) |=> (st_q.dir == $past(wdata)));

    assert_lat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (addr == PB_LAT || addr == PB_PIN)) |=> $stable(st_q.lat));

    assert_lat_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == PB_LAT || addr == PB_PIN)) |=> (st_q.lat == $past(wdata)));
endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux #(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] lat,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] poe,
    input  logic [W-1:0] pdout,
    output logic [W-1:0] out,
    output logic [W-1:0] oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (sel[i]) begin
                out[i] = pdout[i];
                oe[i]  = poe[i];
            end else begin
                out[i] = lat[i];
                oe[i]  = ~dir[i];
            end
        end
    end
endmodule

// File: rtl/pinbank_ovr.sv
module pinbank_ovr
    import pinbank_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PB_AW-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic [W-1:0]     per_sel,
    input  logic [W-1:0]     per_oe,
    input  logic [W-1:0]     per_dout,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     per_din
);
    logic [W-1:0] pin_s;
    logic [W-1:0] dir_w;
    logic [W-1:0] lat_w;

    pinbank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pin_s)
    );

    pinbank_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .pin_sync (pin_s),
        .rdata    (bus_rdata),
        .dir_o    (dir_w),
        .lat_o    (lat_w)
    );

    pinbank_padmux #(.W(W)) u_mux (
        .dir   (dir_w),
        .lat   (lat_w),
        .sel   (per_sel),
        .poe   (per_oe),
        .pdout (per_dout),
        .out   (pad_out),
        .oe    (pad_oe)
    );

    assign per_din = pin_s;

    assert_oe_follows_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PB_DIR) |-> ((pad_oe & ~per_sel) == (~bus_rdata & ~per_sel)));

    assert_out_follows_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PB_LAT) |-> ((pad_out & ~per_sel) == (bus_rdata & ~per_sel)));

    assert_pin_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == PB_PIN) |-> (bus_rdata == per_din));
endmodule

// File: tb/pinbank_ovr_tb.sv
module pinbank_ovr_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] per_sel, per_oe, per_dout, pad_in;
    logic [7:0] pad_out, pad_oe, per_din;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pinbank_ovr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_sel(per_sel),
        .per_oe(per_oe), .per_dout(per_dout), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .per_din(per_din)
    );

    // fields: we, addr, wdata, sel, oe, dout, exp_rdata, exp_out, exp_oe
    localparam int NV = 9;
    localparam logic [58:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'hF0, 8'h00, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F},
        {1'b1, 2'd1, 8'h3C, 8'h00, 8'h00, 8'h00, 8'h3C, 8'h3C, 8'h0F},
        {1'b1, 2'd2, 8'hA5, 8'h00, 8'h00, 8'h00, 8'h5A, 8'hA5, 8'h0F},
        {1'b0, 2'd1, 8'h00, 8'hF0, 8'h30, 8'hCC, 8'hA5, 8'hC5, 8'h3F},
        {1'b0, 2'd0, 8'h00, 8'h0F, 8'h00, 8'hFF, 8'hF0, 8'hAF, 8'h00},
        {1'b1, 2'd3, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h0F},
        {1'b1, 2'd0, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'hA5, 8'hA5, 8'hFF},
        {1'b1, 2'd0, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hA5, 8'h00}
    };

    function automatic string vtag(int idx);
        case (idx)
            0: return "R2";
            1: return "R3";
            2: return "R3/R4";
            3: return "R6";
            4: return "R8";
            5: return "R9";
            6: return "R6";
            7: return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; bus_addr = 2'd0; bus_we = 1'b0; bus_wdata = '0;
        per_sel = '0; per_oe = '0; per_dout = '0; pad_in = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_addr = 2'd0; #0.5;
        check("R1", "dir reset", bus_rdata, 8'hFF);
        check("R1", "oe reset", pad_oe, 8'h00);
        bus_addr = 2'd1; #0.5;
        check("R1", "latch reset", bus_rdata, 8'h00);

        // vector table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            {bus_we, bus_addr, bus_wdata, per_sel, per_oe, per_dout} = VEC[v][58:24];
            @(posedge clk); #1;
            bus_we = 1'b0;
            #0.5;
            check(vtag(v), "rdata", bus_rdata, VEC[v][23:16]);
            check(vtag(v), "pad_out", pad_out, VEC[v][15:8]);
            check(vtag(v), "pad_oe", pad_oe, VEC[v][7:0]);
        end

        // R4 synchronizer latency: change before edge k, visible after edge k+1
        @(negedge clk);
        per_sel = '0; bus_addr = 2'd2; pad_in = 8'hC3;
        @(posedge clk); #1;
        check("R4", "pin read after one edge", bus_rdata, 8'h5A);
        check("R4", "per_din after one edge", per_din, 8'h5A);
        @(posedge clk); #1;
        check("R4", "pin read after two edges", bus_rdata, 8'hC3);
        check("R4", "per_din after two edges", per_din, 8'hC3);

        // R3 latch read is not the pin level
        bus_addr = 2'd1; #0.5;
        check("R3", "latch vs pin", bus_rdata, 8'hA5);

        // R9 write to unused address leaves both registers
        @(negedge clk);
        bus_addr = 2'd3; bus_we = 1'b1; bus_wdata = 8'h00;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_addr = 2'd0; #0.5;
        check("R9", "dir after unused write", bus_rdata, 8'hFF);
        bus_addr = 2'd1; #0.5;
        check("R9", "latch after unused write", bus_rdata, 8'hA5);

        // R1 reset again mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        bus_addr = 2'd1; #0.5;
        check("R1", "latch after second reset", bus_rdata, 8'h00);
        check("R1", "oe after second reset", pad_oe, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule